// File: doc/BRIEF.md
# Calendar Real-Time Clock with Coherent Register Access

This block keeps wall-clock time as six counters (seconds, minutes, hours, day of month, month, year) and advances them from a periodic base tick. A prescaler divides the tick down to one step per second. An enable bit in a control register gates all counting.

A byte-wide register port gives the host access to the time fields and the control register. Reading the seconds byte freezes a copy of all six fields, and the other five time bytes then come from that copy. A multi-byte read is therefore never torn by a rollover. Writes to the first five time bytes go into a staging area. Writing the year byte loads all six fields into the counters in one cycle and restarts the prescaler.

Day and month are stored zero-based. The year is an offset from 2000 held in 6 bits, which gives a range of 2000 to 2063.

Top module: `calendar_rtc`

## Requirements
- R1: After reset, all time fields are zero (2000-01-01 00:00:00), the enable is clear, and the read data output is zero.
- R2: The control register sits at address 0x1D, and bit 2 of it is the enable. It reads back as 0x04 when set and 0x00 when clear. While the enable is clear, neither the counters nor the prescaler advance.
- R3: While enabled, the seconds count advances once for every TICKS_PER_SEC pulses on secTick.
- R4: Seconds and minutes count 0..59 and carry into the next field. Hours count 0..23, and a rollover from 23 advances the day.
- R5: Day is zero-based, so 0..30 means day 1..31. Month is zero-based (0..11). The day rolls over to 0 and the month advances after the last day of the month. Months 3, 5, 8 and 10 have 30 days. Month 1 has 29 days when the year offset is a multiple of 4 and 28 days otherwise. All other months have 31 days.
- R6: One step after offset 63, month 11, day 30, 23:59:59, every field is zero.
- R7: Time bytes sit at addresses 0x0D (seconds), 0x0E (minutes), 0x0F (hours), 0x10 (day), 0x11 (month) and 0x12 (year). A read of 0x0D returns the live seconds and captures all six fields. Reads of 0x0E..0x12 return the captured copy.
- R8: Writes to 0x0D..0x11 are staged and do not change the counters. A write to 0x12 loads the staged fields together with the written year, and it clears the prescaler.
- R9: A written value above the field maximum is clamped to that maximum: 59 for seconds and minutes, 23 for hours, 30 for day, 11 for month. The year keeps the low 6 bits of the written byte.
- R10: Unused bits of the time and control registers read as zero, and every unmapped address reads 0x00.
- R11: Read data appears on regRdata one clock after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | Base tick, one-cycle pulse, TICKS_PER_SEC pulses per second |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 8 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Registered read data |

## Verification
The assertions assume that regRd and regWr are never high in the same cycle, and that secTick is a single-cycle pulse. The hold and commit properties tie the counters to the write strobe on the same edge, so they also assume that regAddr and regWdata are stable whenever a strobe is high. The stimulus drives every strobe for exactly one cycle from the falling clock edge, never overlaps a read with a write, and spaces tick pulses at least one idle cycle apart.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] TIME_BASE = 8'h0D;
  localparam logic [ADDR_W-1:0] YEAR_ADDR = 8'h12;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h1D;
  localparam int FIELD_CNT = 6;
  localparam int EN_BIT = 2;

  typedef struct packed {
    logic [5:0] year;
    logic [3:0] month;
    logic [4:0] day;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } calTime_t;

  typedef struct packed {
    logic       step;
    logic       commit;
    logic       capture;
    logic [FIELD_CNT-2:0] stageWe;
    logic       rdEn;
    logic       rdTime;
    logic       rdLive;
    logic [2:0] rdIdx;
    logic       rdCtrl;
  } rtcStrobes_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output rtcStrobes_t       strb,
  output logic              enable
);
  localparam int PRE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_SEC - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [ADDR_W-1:0] offset;
  logic [2:0]        idx;
  logic              timeHit;
  logic              wrTime;
  logic              commit;

  assign offset  = regAddr - TIME_BASE;
  assign idx     = offset[2:0];
  assign timeHit = (regAddr >= TIME_BASE) && (regAddr <= YEAR_ADDR);
  assign wrTime  = regWr && timeHit;
  assign commit  = wrTime && (idx == 3'(FIELD_CNT - 1));

  always_ff @(posedge clk) begin
    if (!rstN) enable <= 1'b0;
    else if (regWr && (regAddr == CTRL_ADDR)) enable <= regWdata[EN_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN || commit) preCnt <= '0;
    else if (enable && secTick) begin
      if (preCnt == PRE_LAST) preCnt <= '0;
      else preCnt <= preCnt + 1'b1;
    end
  end

  always_comb begin
    strb         = '0;
    strb.step    = enable && secTick && (preCnt == PRE_LAST) && !commit;
    strb.commit  = commit;
    strb.capture = regRd && timeHit && (idx == 3'd0);
    strb.rdEn    = regRd;
    strb.rdTime  = timeHit;
    strb.rdLive  = (idx == 3'd0);
    strb.rdIdx   = idx;
    strb.rdCtrl  = (regAddr == CTRL_ADDR);
    for (int i = 0; i < FIELD_CNT - 1; i++)
      strb.stageWe[i] = wrTime && (idx == 3'(i));
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  rtcStrobes_t strb,
  input  logic        enable,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  output calTime_t    timeNow
);
  calTime_t   snap;
  calTime_t   nextTime;
  calTime_t   staged;
  logic [4:0] lastDay;

  function automatic logic [7:0] clampByte(logic [7:0] v, logic [7:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  function automatic logic [7:0] fieldByte(calTime_t t, logic [2:0] i);
    case (i)
      3'd0:    return {2'b0, t.sec};
      3'd1:    return {2'b0, t.min};
      3'd2:    return {3'b0, t.hour};
      3'd3:    return {3'b0, t.day};
      3'd4:    return {4'b0, t.month};
      default: return {2'b0, t.year};
    endcase
  endfunction

  always_comb begin
    case (timeNow.month)
      4'd1:                      lastDay = (timeNow.year[1:0] == 2'd0) ? 5'd28 : 5'd27;
      4'd3, 4'd5, 4'd8, 4'd10:   lastDay = 5'd29;
      default:                   lastDay = 5'd30;
    endcase
  end

  always_comb begin
    nextTime = timeNow;
    if (timeNow.sec != 6'd59) nextTime.sec = timeNow.sec + 6'd1;
    else begin
      nextTime.sec = '0;
      if (timeNow.min != 6'd59) nextTime.min = timeNow.min + 6'd1;
      else begin
        nextTime.min = '0;
        if (timeNow.hour != 5'd23) nextTime.hour = timeNow.hour + 5'd1;
        else begin
          nextTime.hour = '0;
          if (timeNow.day < lastDay) nextTime.day = timeNow.day + 5'd1;
          else begin
            nextTime.day = '0;
            if (timeNow.month != 4'd11) nextTime.month = timeNow.month + 4'd1;
            else begin
              nextTime.month = '0;
              nextTime.year  = timeNow.year + 6'd1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) staged <= '0;
    else begin
      if (strb.stageWe[0]) staged.sec   <= 6'(clampByte(regWdata, 8'd59));
      if (strb.stageWe[1]) staged.min   <= 6'(clampByte(regWdata, 8'd59));
      if (strb.stageWe[2]) staged.hour  <= 5'(clampByte(regWdata, 8'd23));
      if (strb.stageWe[3]) staged.day   <= 5'(clampByte(regWdata, 8'd30));
      if (strb.stageWe[4]) staged.month <= 4'(clampByte(regWdata, 8'd11));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) timeNow <= '0;
    else if (strb.commit) begin
      timeNow      <= staged;
      timeNow.year <= regWdata[5:0];
    end else if (strb.step) timeNow <= nextTime;
  end

  always_ff @(posedge clk) begin
    if (!rstN) snap <= '0;
    else if (strb.capture) snap <= timeNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) regRdata <= '0;
    else if (strb.rdEn) begin
      if (strb.rdTime)
        regRdata <= strb.rdLive ? {2'b0, timeNow.sec} : fieldByte(snap, strb.rdIdx);
      else if (strb.rdCtrl)
        regRdata <= 8'(enable) << EN_BIT;
      else
        regRdata <= '0;
    end
  end
endmodule

// File: rtl/calendar_rtc.sv
module calendar_rtc
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata
);
  rtcStrobes_t strb;
  calTime_t    timeNow;
  logic        enable;

  rtc_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .strb(strb), .enable(enable)
  );

  rtc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .enable(enable),
    .regWdata(regWdata), .regRdata(regRdata), .timeNow(timeNow)
  );
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk
  import rtc_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       regWr,
  input logic       regRd,
  input logic [7:0] regAddr,
  input logic [7:0] regWdata,
  input logic [7:0] regRdata,
  input logic       enable,
  input calTime_t   timeNow
);
  logic badAddr;
  assign badAddr = ((regAddr < TIME_BASE) || (regAddr > YEAR_ADDR)) && (regAddr != CTRL_ADDR);

  // R4
  clock_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeNow.sec <= 6'd59) && (timeNow.min <= 6'd59) && (timeNow.hour <= 5'd23));

  // R5
  date_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeNow.day <= 5'd30) && (timeNow.month <= 4'd11));

  // R2
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !(regWr && regAddr == YEAR_ADDR)) |=> $stable(timeNow));

  // R8
  commit_year_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == YEAR_ADDR) |=> (timeNow.year == $past(regWdata[5:0])));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && badAddr) |=> (regRdata == 8'h00));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!regRd && !$past(regRd)) |-> $stable(regRdata));
endmodule

bind calendar_rtc rtc_chk u_rtcChk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
  .regWdata(regWdata), .regRdata(regRdata), .enable(enable), .timeNow(timeNow)
);

// File: tb/calendar_rtc_bench.sv
`timescale 1ns/1ps
module calendar_rtc_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secTick = 1'b0;
  logic regWr = 1'b0;
  logic regRd = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;

  int checks = 0;
  int errors = 0;
  logic rdSeen = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  calendar_rtc #(.TICKS_PER_SEC(4)) u_calendar_rtc (
    .clk(clk), .rstN(rstN), .secTick(secTick), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata)
  );

  task automatic checkVal(logic [7:0] act, logic [7:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) rdSeen <= regRd;

  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11: actual=%0d expected=none (unexpected read)", regRdata);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        checkVal(regRdata, it.val, it.tag);
      end
    end
  end

  task automatic writeReg(logic [7:0] a, logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic readExp(logic [7:0] a, logic [7:0] e, string tag);
    expItem_t it;
    it.val = e; it.tag = tag;
    @(negedge clk); regAddr = a; regRd = 1'b1; expQ.push_back(it);
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); secTick = 1'b1;
      @(negedge clk); secTick = 1'b0;
    end
  endtask

  task automatic setTime(logic [7:0] s, logic [7:0] m, logic [7:0] h,
                         logic [7:0] d, logic [7:0] mo, logic [7:0] y);
    writeReg(8'h0D, s); writeReg(8'h0E, m); writeReg(8'h0F, h);
    writeReg(8'h10, d); writeReg(8'h11, mo); writeReg(8'h12, y);
  endtask

  task automatic readAll(logic [7:0] s, logic [7:0] m, logic [7:0] h,
                         logic [7:0] d, logic [7:0] mo, logic [7:0] y, string tag);
    readExp(8'h0D, s, {tag, " sec"});  readExp(8'h0E, m, {tag, " min"});
    readExp(8'h0F, h, {tag, " hour"}); readExp(8'h10, d, {tag, " day"});
    readExp(8'h11, mo, {tag, " month"}); readExp(8'h12, y, {tag, " year"});
  endtask

  task automatic finishUp();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finishUp();
  end

  initial begin
    repeat (3) @(negedge clk);
    checkVal(regRdata, 8'h00, "R1 rdata after reset");
    rstN = 1'b1;
    readAll(0, 0, 0, 0, 0, 0, "R1 reset time");
    readExp(8'h1D, 8'h00, "R1 enable clear");

    tick(8);
    readExp(8'h0D, 8'd0, "R2 disabled no advance");

    writeReg(8'h1D, 8'hFF);
    readExp(8'h1D, 8'h04, "R2 R10 ctrl readback");
    tick(4);
    readExp(8'h0D, 8'd1, "R3 one second after four ticks");
    tick(3);
    readExp(8'h0D, 8'd1, "R3 partial prescale");

    writeReg(8'h0D, 58); writeReg(8'h0E, 59); writeReg(8'h0F, 23);
    writeReg(8'h10, 27); writeReg(8'h11, 1);
    readExp(8'h0D, 8'd1, "R8 staged no effect");
    readExp(8'h0E, 8'd0, "R8 staged minutes no effect");
    writeReg(8'h12, 0);
    tick(1);
    readExp(8'h0D, 8'd58, "R8 prescaler cleared on commit");
    tick(3);
    readExp(8'h0D, 8'd59, "R3 step after commit");
    tick(4);
    readAll(0, 0, 0, 28, 1, 0, "R4 R5 leap Feb 29");

    setTime(59, 59, 23, 27, 1, 1);
    tick(4);
    readAll(0, 0, 0, 0, 2, 1, "R5 non-leap Feb to Mar");

    setTime(59, 59, 23, 29, 3, 5);
    tick(4);
    readAll(0, 0, 0, 0, 4, 5, "R5 Apr 30 to May 1");

    setTime(59, 59, 23, 30, 11, 63);
    tick(4);
    readAll(0, 0, 0, 0, 0, 0, "R6 year wrap");

    setTime(8'hFF, 75, 30, 40, 15, 8'hFF);
    readAll(59, 59, 23, 30, 11, 63, "R9 clamp");

    setTime(59, 10, 5, 3, 6, 20);
    readExp(8'h0D, 8'd59, "R7 live seconds capture");
    tick(4);
    readExp(8'h0E, 8'd10, "R7 snapshot minutes");
    readExp(8'h12, 8'd20, "R7 snapshot year");
    readExp(8'h0D, 8'd0, "R7 live seconds after step");
    readExp(8'h0E, 8'd11, "R7 new snapshot minutes");
    repeat (3) @(negedge clk);
    checkVal(regRdata, 8'd11, "R11 rdata held");

    readExp(8'h00, 8'h00, "R10 unmapped 0x00");
    readExp(8'h13, 8'h00, "R10 unmapped 0x13");
    readExp(8'h1C, 8'h00, "R10 unmapped 0x1C");

    writeReg(8'h1D, 8'h00);
    readExp(8'h1D, 8'h00, "R2 ctrl cleared");
    tick(8);
    readExp(8'h0D, 8'd0, "R2 disabled hold seconds");
    readExp(8'h0E, 8'd11, "R2 disabled hold minutes");

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL R11: actual=%0d expected=0 pending reads", expQ.size());
    end
    finishUp();
  end
endmodule